// File: doc/BRIEF.md
# Regulator Fault Protection Supervisor

This block sits beside the control loop of a multiphase voltage regulator and decides when the power stage must stop switching. Comparators elsewhere produce synchronous single-bit fault flags: overcurrent, severe overcurrent, output too high relative to target, output too low, phase current imbalance, output above an absolute ceiling, and over-temperature. The supervisor qualifies each timed flag with its own persistence counter. On a qualified fault it latches a shutdown, tri-states all PWM outputs and pulls power-good low.

The absolute overvoltage fault needs different handling. It acts on the next clock edge and forces the low-side switches on to discharge the output. It holds them on until a separate flag reports that the output has fallen below the safe level. After that the PWM outputs go to tri-state. Only the supply reset clears this latch. The other shutdown latches clear when the enable input goes low, and the regulator restarts when enable returns high. Over-temperature drives the active-low throttle output and does nothing else. All outputs are decoded from registered state, so each one changes on the clock edge after the input that causes it.

Top module: `vr_fault_supervisor`

## Requirements
- R1: While `rstN` is low, and until an edge samples `enable` high, the outputs are powerGood=0, pwmTristate=1, lowSideOn=0 and throttleN=1. A supply reset clears every latch, including the absolute overvoltage latch.
- R2: With `enable` high and no latch set, the edge that samples `enable` high makes powerGood=1, pwmTristate=0 and lowSideOn=0.
- R3: `ocFlag` shuts down on the OC_LIMIT-th consecutive edge at which it is sampled high. Shutdown means powerGood=0 and pwmTristate=1. A run shorter than the limit causes nothing, and the counter restarts from zero.
- R4: `ocSevereFlag` causes the same shutdown on the SEVERE_LIMIT-th consecutive high sample.
- R5: `ovRelFlag`, `uvFlag` and `imbalFlag` each cause the same shutdown on the SLOW_LIMIT-th consecutive high sample.
- R6: With no latch set, whether `enable` is high or low, `ovAbsFlag` sampled high gives lowSideOn=1, pwmTristate=0 and powerGood=0 after that edge. It wins over a timed fault that qualifies on the same edge.
- R7: During the discharge phase, the edge that samples `dischargedFlag` high gives lowSideOn=0 and pwmTristate=1. powerGood stays 0.
- R8: Toggling `enable` neither releases the absolute overvoltage latch nor changes its outputs.
- R9: A timed-fault latch clears on the edge that samples `enable` low. The outputs are then powerGood=0 and pwmTristate=1, and the next edge that samples `enable` high restores powerGood=1.
- R10: While any latch is set, the flags of other fault classes, `ovAbsFlag` included, do not change the outputs.
- R11: `throttleN` equals the inverse of `hotFlag` sampled at the previous edge, in every state.
- R12: The edge that samples `enable` low sets powerGood to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Supply reset, active low, asynchronous |
| enable | input | 1 | Regulator enable |
| ocFlag | input | 1 | Overcurrent comparator flag |
| ocSevereFlag | input | 1 | Severe overcurrent comparator flag |
| ovRelFlag | input | 1 | Output above target by the relative margin |
| uvFlag | input | 1 | Output below target by the undervoltage margin |
| imbalFlag | input | 1 | Phase current imbalance flag |
| ovAbsFlag | input | 1 | Output above the absolute ceiling |
| dischargedFlag | input | 1 | Output below the safe discharge level |
| hotFlag | input | 1 | Over-temperature flag |
| powerGood | output | 1 | Power-good, high only while regulating |
| pwmTristate | output | 1 | Command to tri-state all PWM outputs |
| lowSideOn | output | 1 | Command to force all low-side switches on |
| throttleN | output | 1 | Thermal throttle request, active low |

## Verification
The main same-cycle collision is an absolute overvoltage flag arriving on the very edge at which the overcurrent counter reaches its limit. The bench holds `ocFlag` for one edge short of the limit and then raises `ovAbsFlag` together with the final overcurrent sample. It expects the discharge outputs (lowSideOn=1, pwmTristate=0) and not the plain tri-state shutdown. A second collision is an over-temperature flag and an enable toggle arriving while a shutdown latch is held. The bench judges these on the scoreboard: the throttle output must follow the flag, and the latched outputs must stay where they were.

// File: rtl/vr_fault_pkg.sv
package vr_fault_pkg;

  // timed fault classes, index into the flag vector
  localparam int NUM_TIMED = 5;
  localparam int T_SEVERE  = 0;
  localparam int T_OC      = 1;
  localparam int T_OVREL   = 2;
  localparam int T_UV      = 3;
  localparam int T_IMBAL   = 4;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,  // enable low, stage off
    ST_RUN    = 3'd1,  // regulating
    ST_TRIP   = 3'd2,  // timed fault latched, tri-stated
    ST_CLAMP  = 3'd3,  // absolute overvoltage, low side forced on
    ST_OVPOFF = 3'd4   // absolute overvoltage, discharged, tri-stated
  } supState_t;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic count;
    logic clear;
  } timerCtl_t;

endpackage

// File: rtl/vr_fault_timers.sv
module vr_fault_timers
  import vr_fault_pkg::*;
#(
  parameter int OC_LIMIT     = 15000,
  parameter int SEVERE_LIMIT = 200,
  parameter int SLOW_LIMIT   = 125000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  timerCtl_t            ctl,
  input  logic [NUM_TIMED-1:0] rawFlags,
  input  logic                 hotFlag,
  output logic [NUM_TIMED-1:0] qualified,
  output logic                 throttleN
);

  localparam int MAX_A  = (OC_LIMIT > SEVERE_LIMIT) ? OC_LIMIT : SEVERE_LIMIT;
  localparam int MAX_LIM = (MAX_A > SLOW_LIMIT) ? MAX_A : SLOW_LIMIT;
  localparam int CW     = $clog2(MAX_LIM + 1);

  for (genvar i = 0; i < NUM_TIMED; i++) begin : g_timer
    localparam int LIM = (i == T_SEVERE) ? SEVERE_LIMIT :
                         (i == T_OC)     ? OC_LIMIT     : SLOW_LIMIT;
    localparam logic [CW-1:0] LAST = CW'(LIM - 1);

    logic [CW-1:0] persistCnt;
    logic          atLimit;

    assign atLimit      = (persistCnt == LAST);
    assign qualified[i] = ctl.count && rawFlags[i] && atLimit;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        persistCnt <= '0;
      end else if (ctl.clear || !rawFlags[i]) begin
        persistCnt <= '0;
      end else if (ctl.count && !atLimit) begin
        persistCnt <= persistCnt + 1'b1;
      end
    end
  end

  // throttle: follows temperature flag, no latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) throttleN <= 1'b1;
    else       throttleN <= ~hotFlag;
  end

endmodule

// File: rtl/vr_fault_ctrl.sv
module vr_fault_ctrl
  import vr_fault_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enable,
  input  logic                 ovAbsFlag,
  input  logic                 dischargedFlag,
  input  logic [NUM_TIMED-1:0] qualified,
  output timerCtl_t            ctl,
  output logic                 powerGood,
  output logic                 pwmTristate,
  output logic                 lowSideOn
);

  supState_t curState, nextState;

  always_comb begin
    nextState = curState;
    unique case (curState)
      ST_IDLE: begin
        if (ovAbsFlag)   nextState = ST_CLAMP;
        else if (enable) nextState = ST_RUN;
      end
      ST_RUN: begin
        if (ovAbsFlag)       nextState = ST_CLAMP;
        else if (|qualified) nextState = ST_TRIP;
        else if (!enable)    nextState = ST_IDLE;
      end
      ST_TRIP: begin
        if (!enable) nextState = ST_IDLE;
      end
      ST_CLAMP: begin
        if (dischargedFlag) nextState = ST_OVPOFF;
      end
      ST_OVPOFF: nextState = ST_OVPOFF;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_IDLE;
    else       curState <= nextState;
  end

  always_comb begin
    ctl.count = (curState == ST_RUN);
    ctl.clear = (curState != ST_RUN);
  end

  assign powerGood   = (curState == ST_RUN);
  assign lowSideOn   = (curState == ST_CLAMP);
  assign pwmTristate = (curState == ST_IDLE) || (curState == ST_TRIP) ||
                       (curState == ST_OVPOFF);

endmodule

// File: rtl/vr_fault_supervisor.sv
module vr_fault_supervisor
  import vr_fault_pkg::*;
#(
  parameter int OC_LIMIT     = 15000,   // 120 us at 125 MHz
  parameter int SEVERE_LIMIT = 200,     // 1.6 us at 125 MHz
  parameter int SLOW_LIMIT   = 125000   // 1 ms at 125 MHz
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic ocFlag,
  input  logic ocSevereFlag,
  input  logic ovRelFlag,
  input  logic uvFlag,
  input  logic imbalFlag,
  input  logic ovAbsFlag,
  input  logic dischargedFlag,
  input  logic hotFlag,
  output logic powerGood,
  output logic pwmTristate,
  output logic lowSideOn,
  output logic throttleN
);

  timerCtl_t            timerCtl;
  logic [NUM_TIMED-1:0] rawFlags;
  logic [NUM_TIMED-1:0] qualified;

  always_comb begin
    rawFlags           = '0;
    rawFlags[T_SEVERE] = ocSevereFlag;
    rawFlags[T_OC]     = ocFlag;
    rawFlags[T_OVREL]  = ovRelFlag;
    rawFlags[T_UV]     = uvFlag;
    rawFlags[T_IMBAL]  = imbalFlag;
  end

  vr_fault_timers #(
    .OC_LIMIT    (OC_LIMIT),
    .SEVERE_LIMIT(SEVERE_LIMIT),
    .SLOW_LIMIT  (SLOW_LIMIT)
  ) u_timers (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (timerCtl),
    .rawFlags (rawFlags),
    .hotFlag  (hotFlag),
    .qualified(qualified),
    .throttleN(throttleN)
  );

  vr_fault_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .enable        (enable),
    .ovAbsFlag     (ovAbsFlag),
    .dischargedFlag(dischargedFlag),
    .qualified     (qualified),
    .ctl           (timerCtl),
    .powerGood     (powerGood),
    .pwmTristate   (pwmTristate),
    .lowSideOn     (lowSideOn)
  );

endmodule

// File: rtl/vr_fault_checker.sv
module vr_fault_checker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic ovAbsFlag,
  input logic hotFlag,
  input logic powerGood,
  input logic pwmTristate,
  input logic lowSideOn,
  input logic throttleN
);

  p_throttle_on_r11: assert property (@(posedge clk) disable iff (!rstN)
    hotFlag |=> !throttleN);

  p_throttle_off_r11: assert property (@(posedge clk) disable iff (!rstN)
    !hotFlag |=> throttleN);

  p_clamp_at_once_r6: assert property (@(posedge clk) disable iff (!rstN)
    (powerGood && ovAbsFlag) |=> (lowSideOn && !powerGood && !pwmTristate));

  p_clamp_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    lowSideOn |=> ((lowSideOn || pwmTristate) && !powerGood));

  p_clamp_exit_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(lowSideOn) && !lowSideOn) |-> pwmTristate);

  p_pg_follows_enable_r12: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !powerGood);

endmodule

bind vr_fault_supervisor vr_fault_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .enable     (enable),
  .ovAbsFlag  (ovAbsFlag),
  .hotFlag    (hotFlag),
  .powerGood  (powerGood),
  .pwmTristate(pwmTristate),
  .lowSideOn  (lowSideOn),
  .throttleN  (throttleN)
);

// File: tb/tb_vr_fault_supervisor.sv
`timescale 1ns/1ps
module tb_vr_fault_supervisor;

  localparam int OC_LIM   = 12;
  localparam int SEV_LIM  = 3;
  localparam int SLOW_LIM = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic ocFlag = 1'b0, ocSevereFlag = 1'b0, ovRelFlag = 1'b0, uvFlag = 1'b0;
  logic imbalFlag = 1'b0, ovAbsFlag = 1'b0, dischargedFlag = 1'b0, hotFlag = 1'b0;
  logic powerGood, pwmTristate, lowSideOn, throttleN;

  always #4 clk = ~clk;  // 125 MHz

  vr_fault_supervisor #(
    .OC_LIMIT(OC_LIM), .SEVERE_LIMIT(SEV_LIM), .SLOW_LIMIT(SLOW_LIM)
  ) dut (
    .clk(clk), .rstN(rstN), .enable(enable), .ocFlag(ocFlag),
    .ocSevereFlag(ocSevereFlag), .ovRelFlag(ovRelFlag), .uvFlag(uvFlag),
    .imbalFlag(imbalFlag), .ovAbsFlag(ovAbsFlag), .dischargedFlag(dischargedFlag),
    .hotFlag(hotFlag), .powerGood(powerGood), .pwmTristate(pwmTristate),
    .lowSideOn(lowSideOn), .throttleN(throttleN)
  );

  typedef struct {
    int    due;
    logic  pg, tz, ls, th;
    string tag;
  } exp_t;

  exp_t expQ[$];
  int   cyc = 0;
  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;

  // monitor: pops expectations that fall due after each edge
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #2;
      while (expQ.size() > 0 && expQ[0].due == cyc) begin
        exp_t e;
        e = expQ.pop_front();
        total++;
        if (powerGood !== e.pg || pwmTristate !== e.tz ||
            lowSideOn !== e.ls || throttleN !== e.th) begin
          bad++;
          $display("FAIL %s: pg/tri/ls/thr actual %b%b%b%b expected %b%b%b%b",
                   e.tag, powerGood, pwmTristate, lowSideOn, throttleN,
                   e.pg, e.tz, e.ls, e.th);
        end
      end
    end
  end

  // driver: push expectation for the next edge, then wait one cycle
  task automatic step(input logic ePg, input logic eTz, input logic eLs, input string tag);
    exp_t e;
    e.due = cyc + 1; e.pg = ePg; e.tz = eTz; e.ls = eLs; e.th = ~hotFlag; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
  endtask

  task automatic expRun(input string tag);   step(1'b1, 1'b0, 1'b0, tag); endtask
  task automatic expOff(input string tag);   step(1'b0, 1'b1, 1'b0, tag); endtask
  task automatic expClamp(input string tag); step(1'b0, 1'b0, 1'b1, tag); endtask

  task automatic reEnable();
    enable = 1'b0; expOff("R9 clear on enable low");
    enable = 1'b1; expRun("R9 restart on enable high");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    expOff("R1 reset state");
    expOff("R1 reset state");
    enable = 1'b1;
    expOff("R1 held in reset with enable high");
    rstN = 1'b1;
    expRun("R2 enable with no fault");
    expRun("R2 steady");

    // R3: short run then restart, then full run
    ocFlag = 1'b1;
    for (int i = 1; i < OC_LIM; i++) expRun("R3 below limit");
    ocFlag = 1'b0; expRun("R3 counter restart");
    ocFlag = 1'b1;
    for (int i = 1; i <= OC_LIM; i++) begin
      if (i < OC_LIM) expRun("R3 counting again");
      else            expOff("R3 trip at limit");
    end
    ocFlag = 1'b0; expOff("R3 latched");

    // R10: other classes ignored while latched; R11 throttle in trip
    ovAbsFlag = 1'b1; expOff("R10 abs ov ignored while tripped");
    ovAbsFlag = 1'b0; uvFlag = 1'b1; expOff("R10 uv ignored while tripped");
    uvFlag = 1'b0;
    hotFlag = 1'b1; expOff("R11 throttle during trip");
    enable = 1'b0;  expOff("R9 clear with throttle active");
    enable = 1'b1;  hotFlag = 1'b0; expRun("R9 restart after trip");

    // R4
    ocSevereFlag = 1'b1;
    for (int i = 1; i <= SEV_LIM; i++) begin
      if (i < SEV_LIM) expRun("R4 severe below limit");
      else             expOff("R4 severe trip");
    end
    ocSevereFlag = 1'b0;
    reEnable();

    // R5: partial uv run, then each slow class
    uvFlag = 1'b1;
    for (int i = 1; i < SLOW_LIM; i++) expRun("R5 uv below limit");
    uvFlag = 1'b0; expRun("R5 uv restart");
    for (int k = 0; k < 3; k++) begin
      ovRelFlag = (k == 0); uvFlag = (k == 1); imbalFlag = (k == 2);
      for (int i = 1; i <= SLOW_LIM; i++) begin
        if (i < SLOW_LIM) expRun("R5 slow class counting");
        else              expOff("R5 slow class trip");
      end
      ovRelFlag = 1'b0; uvFlag = 1'b0; imbalFlag = 1'b0;
      reEnable();
    end

    // R11 and R12 while running
    hotFlag = 1'b1; expRun("R11 throttle while running");
    hotFlag = 1'b0; expRun("R11 throttle release");
    enable = 1'b0;  expOff("R12 pg low after enable low");
    enable = 1'b1;  expRun("R12 pg back");

    // R6: abs ov on the same edge that oc qualifies
    ocFlag = 1'b1;
    for (int i = 1; i < OC_LIM; i++) expRun("R6 oc pre-count");
    ovAbsFlag = 1'b1; expClamp("R6 abs ov wins same edge");
    ocFlag = 1'b0; ovAbsFlag = 1'b0; expClamp("R6 clamp held");
    enable = 1'b0; expClamp("R8 enable low in clamp");
    enable = 1'b1; expClamp("R8 enable high in clamp");
    dischargedFlag = 1'b1; expOff("R7 discharged to tristate");
    dischargedFlag = 1'b0; expOff("R7 held");
    enable = 1'b0; expOff("R8 enable low after discharge");
    enable = 1'b1; expOff("R8 no restart on enable");
    ocFlag = 1'b1;
    for (int i = 0; i < 4; i++) expOff("R10 oc ignored in ovp latch");
    ocFlag = 1'b0;

    // R1: supply reset clears abs ov latch
    rstN = 1'b0; expOff("R1 supply reset");
    rstN = 1'b1; expRun("R1 restart after supply reset");

    // R6 from idle
    enable = 1'b0; expOff("R6 idle");
    ovAbsFlag = 1'b1; expClamp("R6 abs ov from idle");
    ovAbsFlag = 1'b0; expClamp("R6 clamp from idle held");
    rstN = 1'b0; expOff("R1 reset again");
    rstN = 1'b1; expOff("R1 idle after reset");
    enable = 1'b1; expRun("R2 final enable");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule